// File: doc/BRIEF.md
# Host-to-DSP Mailbox and Control Register Block

This block is the register file between a host processor and a signal-processing coprocessor. The host reaches it over a simple synchronous register bus of 16-bit words. Each direction has a mailbox for a 31-bit message. The message is split over a high and a low half-word, and bit 15 of the high half is a valid flag.

The host builds an outbound command in two steps. It first writes the high half, which holds the valid flag and message bits 30:16. It then writes the low half, and that write commits the whole message to the coprocessor at once. In the other direction, the coprocessor posts a reply. The post sets a valid flag and raises a coprocessor interrupt status. The host's read of the reply's low half retires the reply.

A control/status word handles the following:
- Three interrupt sources, each with a mask and a write-one-to-clear status bit.
- A fourth status bit for the DMA source, which has no mask.
- A held halt level and a held interrupt request toward the coprocessor.
- A reset strobe for the coprocessor that clears itself.

Top module: `hdm_regs`

## Requirements
- R1: After reset, all five registers read 0, and the outputs `dsp_msg_valid_o`, `dsp_halt_o`, `dsp_reset_o`, `dsp_irq_o` and `host_irq_o` are all 0.
- R2: A write to offset 0x00 stores a staged valid flag (bit 15) and message bits 30:16 (bits 14:0). On its own it does not change `dsp_msg_o` or `dsp_msg_valid_o`. A following write to offset 0x02 presents `{staged bits, written low half}` on `dsp_msg_o`, and sets `dsp_msg_valid_o` to the staged flag.
- R3: A pulse on `dsp_msg_ack_i` clears the inbound valid flag. A low-half write in the same cycle takes priority over the acknowledge.
- R4: Offset 0x00 reads `{inbound valid, staged bits 14:0}`. Offset 0x02 reads the committed low half.
- R5: A pulse on `dsp_post_i` stores `dsp_post_msg_i` and sets the outbound valid flag. Offset 0x04 then reads `{1, msg[30:16]}` and offset 0x06 reads `msg[15:0]`. The post also sets control bit 7 (coprocessor status).
- R6: A host read of offset 0x06 clears the outbound valid flag. A post in the same cycle keeps it set. Reads of 0x04 and host writes to 0x04 or 0x06 change nothing.
- R7: Status bits 3 (audio interface), 5 (audio RAM), 7 (coprocessor) and 9 (DMA) behave as follows:
  - Each is set by its event input.
  - Writing 1 to offset 0x0A at that bit clears it, and writing 0 leaves it unchanged.
  - An event in the same cycle as a clear takes priority, so the bit stays set.
- R8: `host_irq_o` is the OR of each status bit ANDed with its mask. The mask pairs are bit 3 with bit 4, bit 5 with bit 6, and bit 7 with bit 8. DMA status bit 9 never drives `host_irq_o`.
- R9: Writing 1 to control bit 0 drives `dsp_reset_o` high for exactly the one cycle after the write. Bit 0 always reads 0.
- R10: Control bit 2 (halt) and bit 1 (interrupt request) drive `dsp_halt_o` and `dsp_irq_o`. Both hold their written value until the next control write. Control bits 15:10 read 0.
- R11: Driving `rst_ni` low clears all state at once, without waiting for a clock edge. Release of reset takes effect after the synchronizer stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_sel_i | input | 1 | Host bus access this cycle |
| host_wr_i | input | 1 | 1 = write, 0 = read |
| host_addr_i | input | ADDR_W | Byte offset of the register |
| host_wdata_i | input | DATA_W | Host write data |
| host_rdata_o | output | DATA_W | Read data for the addressed register (combinational) |
| host_irq_o | output | 1 | Masked interrupt to the host |
| dsp_msg_o | output | 2*DATA_W-1 | Committed inbound message |
| dsp_msg_valid_o | output | 1 | Inbound message is valid |
| dsp_msg_ack_i | input | 1 | Coprocessor has consumed the inbound message |
| dsp_post_i | input | 1 | Coprocessor posts an outbound message |
| dsp_post_msg_i | input | 2*DATA_W-1 | Outbound message payload |
| ev_aud_i | input | 1 | Audio-interface interrupt event |
| ev_aram_i | input | 1 | Audio-RAM interrupt event |
| ev_dma_i | input | 1 | DMA interrupt event |
| dsp_halt_o | output | 1 | Halt level to the coprocessor |
| dsp_reset_o | output | 1 | One-cycle reset strobe to the coprocessor |
| dsp_irq_o | output | 1 | Interrupt request to the coprocessor |

## Verification
The bench builds the block with DATA_W=16, ADDR_W=4 and SYNC_STAGES=2.

The 16-bit width gives the 31-bit message and the control bit positions 0 to 9 with unused bits 15:10. That makes the message split, the valid-flag position and the unused read-back bits all directly observable. A 4-bit address covers all five offsets and the unmapped holes between them. Two synchronizer stages keep the reset release short, so the asynchronous clear and the later release can both be exercised. The same-cycle races (event against clear, post against read, low-half write against acknowledge) are driven deliberately.

// File: rtl/hdm_pkg.sv
package hdm_pkg;
  // byte offsets of the host-visible registers
  localparam logic [7:0] OFS_IN_HI  = 8'h00;
  localparam logic [7:0] OFS_IN_LO  = 8'h02;
  localparam logic [7:0] OFS_OUT_HI = 8'h04;
  localparam logic [7:0] OFS_OUT_LO = 8'h06;
  localparam logic [7:0] OFS_CTRL   = 8'h0A;

  // control word layout
  localparam int unsigned CTRL_W      = 10;
  localparam int unsigned CB_RST      = 0;
  localparam int unsigned CB_DIRQ     = 1;
  localparam int unsigned CB_HALT     = 2;
  localparam int unsigned CB_SRC_BASE = 3;  // status at base+2i, mask at base+2i+1
  localparam int unsigned CB_DMA_ST   = 9;

  // masked sources: 0 audio interface, 1 audio RAM, 2 coprocessor
  localparam int unsigned N_SRC = 3;
endpackage

// File: rtl/hdm_rst_sync.sv
module hdm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sh_q[STAGES-1];
endmodule

// File: rtl/hdm_inbox.sv
module hdm_inbox #(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned MSG_W = 2 * DATA_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hi_wr_i,
  input  logic              lo_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ack_i,
  output logic [DATA_W-1:0] hi_rd_o,
  output logic [DATA_W-1:0] lo_rd_o,
  output logic [MSG_W-1:0]  msg_o,
  output logic              valid_o
);
  logic [DATA_W-2:0] stage_q, msg_hi_q;
  logic [DATA_W-1:0] lo_q;
  logic              arm_q, valid_q, valid_d;

  // next state: a commit beats an acknowledge in the same cycle
  always_comb begin
    valid_d = valid_q;
    if (ack_i)   valid_d = 1'b0;
    if (lo_wr_i) valid_d = arm_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q  <= '0;
      arm_q    <= 1'b0;
      msg_hi_q <= '0;
      lo_q     <= '0;
      valid_q  <= 1'b0;
    end else begin
      if (hi_wr_i) begin
        stage_q <= wdata_i[DATA_W-2:0];
        arm_q   <= wdata_i[DATA_W-1];
      end
      if (lo_wr_i) begin
        msg_hi_q <= stage_q;
        lo_q     <= wdata_i;
      end
      valid_q <= valid_d;
    end
  end

  assign hi_rd_o = {valid_q, stage_q};
  assign lo_rd_o = lo_q;
  assign msg_o   = {msg_hi_q, lo_q};
  assign valid_o = valid_q;

  p_lo_latch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_wr_i |=> msg_o[DATA_W-1:0] == $past(wdata_i));
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lo_wr_i && !ack_i) |=> ($stable(msg_o) && $stable(valid_o)));
  p_ack_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !lo_wr_i) |=> !valid_o);
endmodule

// File: rtl/hdm_outbox.sv
module hdm_outbox #(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned MSG_W = 2 * DATA_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              post_i,
  input  logic [MSG_W-1:0]  post_data_i,
  input  logic              lo_rd_i,
  output logic [DATA_W-1:0] hi_rd_o,
  output logic [DATA_W-1:0] lo_rd_o
);
  logic [MSG_W-1:0] msg_q;
  logic             valid_q, valid_d;

  // next state: a fresh post beats the retiring read
  always_comb begin
    valid_d = valid_q;
    if (lo_rd_i) valid_d = 1'b0;
    if (post_i)  valid_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msg_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      if (post_i) msg_q <= post_data_i;
      valid_q <= valid_d;
    end
  end

  assign hi_rd_o = {valid_q, msg_q[MSG_W-1:DATA_W]};
  assign lo_rd_o = msg_q[DATA_W-1:0];

  p_post_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    post_i |=> (hi_rd_o[DATA_W-1] && {hi_rd_o[DATA_W-2:0], lo_rd_o} == $past(post_data_i)));
  p_rdclr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_rd_i && !post_i) |=> !hi_rd_o[DATA_W-1]);
  p_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !post_i |=> ($stable(lo_rd_o) && $stable(hi_rd_o[DATA_W-2:0])));
endmodule

// File: rtl/hdm_ctrl.sv
module hdm_ctrl
  import hdm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic [N_SRC-1:0]  src_ev_i,
  input  logic              dma_ev_i,
  output logic [CTRL_W-1:0] rdata_o,
  output logic              dsp_reset_o,
  output logic              dsp_irq_o,
  output logic              dsp_halt_o,
  output logic              host_irq_o
);
  logic [N_SRC-1:0] st_q, st_d, mk_q, mk_wr;
  logic             dma_q, dma_d, halt_q, dirq_q, rstp_q, rstp_d;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    localparam int unsigned ST_B = CB_SRC_BASE + 2 * i;
    localparam int unsigned MK_B = ST_B + 1;
    // set by event has priority over write-1 clear
    assign st_d[i]  = src_ev_i[i] | (st_q[i] & ~(wr_i & wdata_i[ST_B]));
    assign mk_wr[i] = wdata_i[MK_B];

    p_set_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      src_ev_i[i] |=> rdata_o[ST_B]);
    p_w1c_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && wdata_i[ST_B] && !src_ev_i[i]) |=> !rdata_o[ST_B]);
  end

  always_comb begin
    dma_d  = dma_ev_i | (dma_q & ~(wr_i & wdata_i[CB_DMA_ST]));
    rstp_d = wr_i & wdata_i[CB_RST];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= '0;
      mk_q   <= '0;
      dma_q  <= 1'b0;
      halt_q <= 1'b0;
      dirq_q <= 1'b0;
      rstp_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      dma_q  <= dma_d;
      rstp_q <= rstp_d;
      if (wr_i) begin
        mk_q   <= mk_wr;
        halt_q <= wdata_i[CB_HALT];
        dirq_q <= wdata_i[CB_DIRQ];
      end
    end
  end

  always_comb begin
    rdata_o            = '0;
    rdata_o[CB_DIRQ]   = dirq_q;
    rdata_o[CB_HALT]   = halt_q;
    rdata_o[CB_DMA_ST] = dma_q;
    for (int i = 0; i < N_SRC; i++) begin
      rdata_o[CB_SRC_BASE + 2 * i]     = st_q[i];
      rdata_o[CB_SRC_BASE + 2 * i + 1] = mk_q[i];
    end
  end

  assign dsp_reset_o = rstp_q;
  assign dsp_irq_o   = dirq_q;
  assign dsp_halt_o  = halt_q;
  assign host_irq_o  = |(st_q & mk_q);

  p_rst_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dsp_reset_o |-> $past(wr_i && wdata_i[CB_RST]));
  p_level_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> ($stable(dsp_halt_o) && $stable(dsp_irq_o)));
  p_irq_masked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_irq_o |-> (rdata_o[4] || rdata_o[6] || rdata_o[8]));
endmodule

// File: rtl/hdm_regs.sv
module hdm_regs
  import hdm_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned MSG_W      = 2 * DATA_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_sel_i,
  input  logic              host_wr_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic              host_irq_o,
  output logic [MSG_W-1:0]  dsp_msg_o,
  output logic              dsp_msg_valid_o,
  input  logic              dsp_msg_ack_i,
  input  logic              dsp_post_i,
  input  logic [MSG_W-1:0]  dsp_post_msg_i,
  input  logic              ev_aud_i,
  input  logic              ev_aram_i,
  input  logic              ev_dma_i,
  output logic              dsp_halt_o,
  output logic              dsp_reset_o,
  output logic              dsp_irq_o
);
  localparam logic [ADDR_W-1:0] A_IN_HI  = ADDR_W'(OFS_IN_HI);
  localparam logic [ADDR_W-1:0] A_IN_LO  = ADDR_W'(OFS_IN_LO);
  localparam logic [ADDR_W-1:0] A_OUT_HI = ADDR_W'(OFS_OUT_HI);
  localparam logic [ADDR_W-1:0] A_OUT_LO = ADDR_W'(OFS_OUT_LO);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);

  logic              rst_s;
  logic              wr_stb, rd_stb;
  logic              wr_in_hi, wr_in_lo, wr_ctrl, rd_out_lo;
  logic [DATA_W-1:0] in_hi_rd, in_lo_rd, out_hi_rd, out_lo_rd;
  logic [CTRL_W-1:0] ctrl_rd;
  logic [N_SRC-1:0]  src_ev;

  hdm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i (clk_i), .rst_ni(rst_ni), .rst_no(rst_s)
  );

  always_comb begin
    wr_stb    = host_sel_i & host_wr_i;
    rd_stb    = host_sel_i & ~host_wr_i;
    wr_in_hi  = wr_stb & (host_addr_i == A_IN_HI);
    wr_in_lo  = wr_stb & (host_addr_i == A_IN_LO);
    wr_ctrl   = wr_stb & (host_addr_i == A_CTRL);
    rd_out_lo = rd_stb & (host_addr_i == A_OUT_LO);
  end

  hdm_inbox #(.DATA_W(DATA_W)) u_inbox (
    .clk_i  (clk_i),
    .rst_ni (rst_s),
    .hi_wr_i(wr_in_hi),
    .lo_wr_i(wr_in_lo),
    .wdata_i(host_wdata_i),
    .ack_i  (dsp_msg_ack_i),
    .hi_rd_o(in_hi_rd),
    .lo_rd_o(in_lo_rd),
    .msg_o  (dsp_msg_o),
    .valid_o(dsp_msg_valid_o)
  );

  hdm_outbox #(.DATA_W(DATA_W)) u_outbox (
    .clk_i      (clk_i),
    .rst_ni     (rst_s),
    .post_i     (dsp_post_i),
    .post_data_i(dsp_post_msg_i),
    .lo_rd_i    (rd_out_lo),
    .hi_rd_o    (out_hi_rd),
    .lo_rd_o    (out_lo_rd)
  );

  assign src_ev = {dsp_post_i, ev_aram_i, ev_aud_i};

  hdm_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_s),
    .wr_i       (wr_ctrl),
    .wdata_i    (host_wdata_i[CTRL_W-1:0]),
    .src_ev_i   (src_ev),
    .dma_ev_i   (ev_dma_i),
    .rdata_o    (ctrl_rd),
    .dsp_reset_o(dsp_reset_o),
    .dsp_irq_o  (dsp_irq_o),
    .dsp_halt_o (dsp_halt_o),
    .host_irq_o (host_irq_o)
  );

  always_comb begin
    case (host_addr_i)
      A_IN_HI:  host_rdata_o = in_hi_rd;
      A_IN_LO:  host_rdata_o = in_lo_rd;
      A_OUT_HI: host_rdata_o = out_hi_rd;
      A_OUT_LO: host_rdata_o = out_lo_rd;
      A_CTRL:   host_rdata_o = DATA_W'(ctrl_rd);
      default:  host_rdata_o = '0;
    endcase
  end

  p_unused_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_s)
    (host_addr_i == A_CTRL) |-> host_rdata_o[DATA_W-1:CTRL_W] == '0);
  p_dma_no_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_s)
    (host_rdata_o == DATA_W'(10'h200) && host_addr_i == A_CTRL) |-> !host_irq_o);
endmodule

// File: tb/hdm_regs_tb.sv
module hdm_regs_tb_top;
  localparam int unsigned DW = 16;
  localparam int unsigned AW = 4;
  localparam int unsigned MW = 2 * DW - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          host_irq, msg_valid, ack = 1'b0, post = 1'b0;
  logic [MW-1:0] msg, post_msg = '0;
  logic          ev_aud = 1'b0, ev_aram = 1'b0, ev_dma = 1'b0;
  logic          halt, dreset, dirq;

  int total = 0;
  int bad   = 0;

  typedef struct {
    logic [DW-1:0] exp;
    string         req;
  } sb_t;
  sb_t           sb_q[$];
  logic [DW-1:0] smp_act;
  event          smp_ev;

  always #5 clk = ~clk;

  hdm_regs #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .host_sel_i(sel), .host_wr_i(wr), .host_addr_i(addr),
    .host_wdata_i(wdata), .host_rdata_o(rdata), .host_irq_o(host_irq),
    .dsp_msg_o(msg), .dsp_msg_valid_o(msg_valid), .dsp_msg_ack_i(ack),
    .dsp_post_i(post), .dsp_post_msg_i(post_msg),
    .ev_aud_i(ev_aud), .ev_aram_i(ev_aram), .ev_dma_i(ev_dma),
    .dsp_halt_o(halt), .dsp_reset_o(dreset), .dsp_irq_o(dirq)
  );

  // monitor: compares each sampled read with the queued expectation
  initial begin
    forever begin
      @(smp_ev);
      if (sb_q.size() == 0) begin
        total++; bad++;
        $display("FAIL scoreboard: read with no expectation, actual=%h", smp_act);
      end else begin
        sb_t it;
        it = sb_q.pop_front();
        total++;
        if (smp_act !== it.exp) begin
          bad++;
          $display("FAIL %s: read actual=%h expected=%h", it.req, smp_act, it.exp);
        end
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  // read whose sample is taken before the edge that applies side effects
  task automatic hread(logic [AW-1:0] a, logic [DW-1:0] exp, string req);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = a;
    #1;
    sb_q.push_back('{exp: exp, req: req});
    smp_act = rdata;
    -> smp_ev;
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(5);

    // R1: reset state
    hread(4'h0, 16'h0000, "R1");
    hread(4'h2, 16'h0000, "R1");
    hread(4'h4, 16'h0000, "R1");
    hread(4'h6, 16'h0000, "R1");
    hread(4'hA, 16'h0000, "R1");
    chk("R1", {msg_valid, halt, dreset, dirq, host_irq}, 0);

    // R2: staging the high half alone changes nothing toward the coprocessor
    hwrite(4'h0, 16'h9234);
    chk("R2", msg_valid, 0);
    chk("R2", msg, 0);
    hwrite(4'h2, 16'hBEEF);
    chk("R2", msg, 31'h1234BEEF);
    chk("R2", msg_valid, 1);
    // R4: host readback
    hread(4'h0, 16'h9234, "R4");
    hread(4'h2, 16'hBEEF, "R4");
    // R3: acknowledge clears valid
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    chk("R3", msg_valid, 0);
    hread(4'h0, 16'h1234, "R3");
    // R2: commit with the staged flag clear keeps valid low
    hwrite(4'h0, 16'h0055);
    hwrite(4'h2, 16'h0001);
    chk("R2", msg_valid, 0);
    chk("R2", msg, 31'h00550001);
    // R3: commit beats acknowledge in the same cycle
    hwrite(4'h0, 16'hFFFF);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = 4'h2; wdata = 16'h0002; ack = 1'b1;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0; ack = 1'b0;
    chk("R3", msg_valid, 1);
    chk("R3", msg, 31'h7FFF0002);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;

    // R5: coprocessor posts a reply
    @(negedge clk); post = 1'b1; post_msg = 31'h2ABCDEF1;
    @(negedge clk); post = 1'b0;
    hread(4'h4, 16'hAABC, "R5");
    hread(4'hA, 16'h0080, "R5");
    chk("R5", host_irq, 0);
    // R6: high read keeps valid, low read retires it, writes ignored
    hread(4'h4, 16'hAABC, "R6");
    hread(4'h6, 16'hDEF1, "R6");
    hread(4'h4, 16'h2ABC, "R6");
    hwrite(4'h4, 16'hFFFF);
    hwrite(4'h6, 16'hFFFF);
    hread(4'h4, 16'h2ABC, "R6");
    hread(4'h6, 16'hDEF1, "R6");
    // R6: post in the same cycle as the retiring read keeps valid
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = 4'h6; post = 1'b1; post_msg = 31'h00001111;
    #1;
    sb_q.push_back('{exp: 16'hDEF1, req: "R6"});
    smp_act = rdata;
    -> smp_ev;
    @(negedge clk);
    sel = 1'b0; post = 1'b0;
    hread(4'h4, 16'h8000, "R6");
    hread(4'h6, 16'h1111, "R6");
    hread(4'h4, 16'h0000, "R6");

    // R7: write-one-to-clear status
    hwrite(4'hA, 16'h0000);
    hread(4'hA, 16'h0080, "R7");
    hwrite(4'hA, 16'h0080);
    hread(4'hA, 16'h0000, "R7");
    @(negedge clk); ev_aud = 1'b1; ev_aram = 1'b1; ev_dma = 1'b1;
    @(negedge clk); ev_aud = 1'b0; ev_aram = 1'b0; ev_dma = 1'b0;
    hread(4'hA, 16'h0228, "R7");
    hwrite(4'hA, 16'h0200);
    hread(4'hA, 16'h0028, "R7");
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = 4'hA; wdata = 16'h0008; ev_aud = 1'b1;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0; ev_aud = 1'b0;
    hread(4'hA, 16'h0028, "R7");
    hwrite(4'hA, 16'h0028);
    hread(4'hA, 16'h0000, "R7");

    // R8: masking of the host interrupt
    @(negedge clk); ev_aud = 1'b1;
    @(negedge clk); ev_aud = 1'b0;
    chk("R8", host_irq, 0);
    hwrite(4'hA, 16'h0010);
    chk("R8", host_irq, 1);
    hread(4'hA, 16'h0018, "R8");
    hwrite(4'hA, 16'h0018);
    chk("R8", host_irq, 0);
    hwrite(4'hA, 16'h0150);
    @(negedge clk); ev_dma = 1'b1;
    @(negedge clk); ev_dma = 1'b0;
    chk("R8", host_irq, 0);
    hread(4'hA, 16'h0350, "R8");
    @(negedge clk); ev_aram = 1'b1;
    @(negedge clk); ev_aram = 1'b0;
    chk("R8", host_irq, 1);
    hwrite(4'hA, 16'h0220);
    chk("R8", host_irq, 0);
    hread(4'hA, 16'h0000, "R8");

    // R9: reset strobe lasts one cycle and reads 0
    hwrite(4'hA, 16'h0001);
    chk("R9", dreset, 1);
    @(negedge clk);
    chk("R9", dreset, 0);
    hread(4'hA, 16'h0000, "R9");

    // R10: held levels and unused bits
    hwrite(4'hA, 16'h0006);
    idle(3);
    chk("R10", {halt, dirq}, 2'b11);
    hread(4'hA, 16'h0006, "R10");
    hwrite(4'hA, 16'hFC00);
    hread(4'hA, 16'h0000, "R10");
    chk("R10", {halt, dirq}, 2'b00);

    // R11: asynchronous clear between edges
    hwrite(4'hA, 16'h0004);
    hwrite(4'h0, 16'h8000);
    hwrite(4'h2, 16'h0000);
    chk("R11", {halt, msg_valid}, 2'b11);
    @(negedge clk); #2;
    rst_n = 1'b0;
    #1;
    chk("R11", {halt, msg_valid}, 2'b00);
    @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    hread(4'hA, 16'h0000, "R11");
    hread(4'h0, 16'h0000, "R11");

    idle(2);
    if (sb_q.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard: actual=%0d pending expected=0", sb_q.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule